// File: doc/BRIEF.md
# Bus-Hold Transfer Controller

This block lets a peripheral move a programmed run of words into memory without the host processor's help. A pulse on the peripheral's request line makes the controller ask the processor for the bus with a hold request. It then waits for the hold grant before it drives any memory control. Once granted, it writes one word per cycle from the peripheral's data register to consecutive memory addresses. On each word it pulses an acknowledge back to the peripheral. While the controller does not own the bus, its address, data, strobe and write-enable outputs stay inactive, and its output-enable stays low.

The processor loads four things with a single configuration strobe: the start address, the word count, the block size and the mode. In continuous mode the whole run finishes inside one hold period. In chunked mode the controller releases the bus after each block, and it waits for another peripheral request before it takes the bus again. A request that arrives while the bus is held is remembered and used for the next block. When the last word is written, a done level is set and a one-cycle done pulse is raised. The next configuration strobe clears the done level.

Top module: `dma_hold_ctrl`

## Requirements
- R1: After a synchronous active-low reset, hold_req, bus_oe, mem_strobe, mem_we, per_ack, done and done_pulse are all 0, and mem_addr and mem_wdata are 0.
- R2: In idle with a nonzero remaining count, a per_req sampled high at a clock edge drives hold_req high in the cycle after that edge.
- R3: bus_oe, mem_strobe, mem_we and per_ack are high only while hold_req and hlda are both high. The first word appears in the cycle after the edge where hlda is first sampled high. When bus_oe is low, mem_addr and mem_wdata are 0.
- R4: Word k of a run (k = 0, 1, ...) is written at mem_addr = start address + k, modulo 2^AW. mem_wdata equals per_data in the same cycle, and per_ack is high in that cycle.
- R5: In chunked mode (cfg_chunked = 1), each hold period moves the smaller of the block size and the remaining count. A block size of 0 behaves as 1. After a block, no new hold_req is raised until a peripheral request is seen.
- R6: In continuous mode (cfg_chunked = 0), all words move in a single hold period.
- R7: hold_req falls in the cycle after the last word of a block or run. A new hold_req never rises while hlda is high.
- R8: A per_req pulse seen while a hold is requested, granted or being released is latched. It starts the next block without another request.
- R9: The cycle after the final word, done goes high and done_pulse is high for exactly one cycle. done then stays high until a cfg_load is accepted.
- R10: cfg_load is accepted only when the controller is idle; at any other time it has no effect. A run loaded with a count of 0 never raises hold_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_start_addr | input | AW | First memory address |
| cfg_word_cnt | input | CW | Number of words to move |
| cfg_blk_size | input | CW | Words per block in chunked mode |
| cfg_chunked | input | 1 | 1 = chunked mode, 0 = continuous mode |
| per_req | input | 1 | Peripheral transfer request |
| per_data | input | DW | Peripheral data register value |
| per_ack | output | 1 | Word taken from the peripheral this cycle |
| hold_req | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Hold grant from the processor |
| bus_oe | output | 1 | Controller drives the bus |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_strobe | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | Run complete (level) |
| done_pulse | output | 1 | Run complete (one cycle) |

## Verification
Every response is due one edge after its cause:
- hold_req follows a sampled request by one edge.
- The first word follows the sampled grant by one edge.
- hold_req, done and done_pulse change on the edge after the last word.

The bench keeps a behavioural model that steps on the same rising edge as the design, from the same pre-edge inputs. It compares every output on the falling edge, so each expected value is read exactly one register stage after its stimulus. Directed checks count the words in each hold period and the number of hold periods, and confirm that hold_req stays low where a request or reload must be ignored.

// File: rtl/dma_pkg.sv
// Shared types for the bus-hold transfer controller.
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } dma_st_t;
endpackage

// File: rtl/dma_xfer_cnt.sv
// Address, remaining-word and block counters.
// Assumes load and blk_start never coincide with step.
module dma_xfer_cnt #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_cnt,
    input  logic [CW-1:0] ld_bs,
    input  logic          blk_start,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          rem_zero,
    output logic          rem_last,
    output logic          blk_last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] rem_q, blk_q, bs_q;

    // Current address: loaded by configuration, advanced per word.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= ld_addr;
        else if (step) addr <= addr + AW'(1);
    end

    // Remaining words and stored block size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            bs_q  <= '0;
        end else if (load) begin
            rem_q <= ld_cnt;
            bs_q  <= ld_bs;
        end else if (step) begin
            rem_q <= rem_q - ONE;
        end
    end

    // Words left in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)         blk_q <= '0;
        else if (blk_start) blk_q <= bs_q;
        else if (step)      blk_q <= blk_q - ONE;
    end

    assign rem_zero = (rem_q == '0);
    assign rem_last = (rem_q == ONE);
    assign blk_last = (blk_q <= ONE);
endmodule

// File: rtl/dma_hs_fsm.sv
// Hold/grant handshake sequencer with request latch and completion flags.
// Assumes the processor only raises hlda while hold_req is high.
module dma_hs_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  logic cfg_chunked,
    input  logic per_req,
    input  logic hlda,
    input  logic rem_zero,
    input  logic rem_last,
    input  logic blk_last,
    output logic load_ok,
    output logic blk_start,
    output logic step,
    output logic hold_req,
    output logic bus_oe,
    output logic done,
    output logic done_pulse
);
    dma_st_t st_q, st_d;
    logic    pend_q, chunk_q;
    logic    end_blk;

    assign load_ok   = cfg_load && (st_q == ST_IDLE);
    assign blk_start = (st_q == ST_REQ) && hlda;
    assign step      = (st_q == ST_XFER) && hlda;
    assign end_blk   = step && (rem_last || (chunk_q && blk_last));
    assign hold_req  = (st_q == ST_REQ) || (st_q == ST_XFER);
    assign bus_oe    = step;

    // Next-state selection for the handshake.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (!load_ok && (pend_q || per_req) && !rem_zero) st_d = ST_REQ;
            ST_REQ:  if (hlda) st_d = ST_XFER;
            ST_XFER: if (end_blk) st_d = ST_REL;
            ST_REL:  if (!hlda) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request latch: set outside idle, consumed when a hold is raised.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pend_q <= 1'b0;
        else if (load_ok)                             pend_q <= 1'b0;
        else if (st_q == ST_IDLE && st_d == ST_REQ)   pend_q <= 1'b0;
        else if (st_q != ST_IDLE && per_req)          pend_q <= 1'b1;
    end

    // Mode capture on configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)       chunk_q <= 1'b0;
        else if (load_ok) chunk_q <= cfg_chunked;
    end

    // Completion level and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= step && rem_last;
            if (load_ok)               done <= 1'b0;
            else if (step && rem_last) done <= 1'b1;
        end
    end

    // R7
    new_hold_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> !hlda);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

// File: rtl/dma_hold_ctrl.sv
// Top: single-channel peripheral-to-memory transfer controller that
// obtains the bus through a hold/grant handshake. Outputs toward memory
// are zero whenever the controller does not own the bus.
module dma_hold_ctrl #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_start_addr,
    input  logic [CW-1:0] cfg_word_cnt,
    input  logic [CW-1:0] cfg_blk_size,
    input  logic          cfg_chunked,
    input  logic          per_req,
    input  logic [DW-1:0] per_data,
    output logic          per_ack,
    output logic          hold_req,
    input  logic          hlda,
    output logic          bus_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_strobe,
    output logic          mem_we,
    output logic          done,
    output logic          done_pulse
);
    logic          load_ok, blk_start, step;
    logic          rem_zero, rem_last, blk_last;
    logic [AW-1:0] cur_addr;

    dma_xfer_cnt #(.AW(AW), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(load_ok), .ld_addr(cfg_start_addr), .ld_cnt(cfg_word_cnt),
        .ld_bs(cfg_blk_size), .blk_start(blk_start), .step(step),
        .addr(cur_addr), .rem_zero(rem_zero), .rem_last(rem_last),
        .blk_last(blk_last)
    );

    dma_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_chunked(cfg_chunked), .per_req(per_req),
        .hlda(hlda), .rem_zero(rem_zero), .rem_last(rem_last),
        .blk_last(blk_last), .load_ok(load_ok), .blk_start(blk_start),
        .step(step), .hold_req(hold_req), .bus_oe(bus_oe),
        .done(done), .done_pulse(done_pulse)
    );

    // Bus drive gated by ownership.
    assign mem_addr   = bus_oe ? cur_addr : '0;
    assign mem_wdata  = bus_oe ? per_data : '0;
    assign mem_strobe = bus_oe;
    assign mem_we     = bus_oe;
    assign per_ack    = bus_oe;

    // R3
    drive_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (hold_req && hlda));
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> (mem_addr == AW'($past(mem_addr) + AW'(1))));
    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done && !hold_req));
endmodule

// File: tb/test_dma_hold_ctrl.sv
module test_dma_hold_ctrl;
    localparam int AW = 16, DW = 8, CW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_load = 1'b0, cfg_chunked = 1'b0, per_req = 1'b0, hlda = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [CW-1:0] cfg_word_cnt = '0, cfg_blk_size = '0;
    logic [DW-1:0] per_data = '0;
    logic per_ack, hold_req, bus_oe, mem_strobe, mem_we, done, done_pulse;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int errors = 0, checks = 0;
    int lat = 1, cpu_cnt = 0;

    always #2 clk = ~clk;

    dma_hold_ctrl #(.AW(AW), .DW(DW), .CW(CW)) i_dma_hold_ctrl (.*);

    // Processor model: grant after lat cycles of request, drop on release.
    always @(posedge clk) begin
        if (!hold_req) begin
            hlda <= 1'b0; cpu_cnt <= 0;
        end else if (!hlda) begin
            cpu_cnt <= cpu_cnt + 1;
            if (cpu_cnt + 1 >= lat) hlda <= 1'b1;
        end
    end

    // Behavioural reference model.
    int m_st = 0, m_rem = 0, m_blk = 0, m_bs = 0;
    bit m_pend = 0, m_ch = 0, m_done = 0, m_dp = 0;
    logic [AW-1:0] m_addr = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_rem <= 0; m_blk <= 0; m_bs <= 0; m_pend <= 0;
            m_ch <= 0; m_done <= 0; m_dp <= 0; m_addr <= '0;
        end else begin
            m_dp <= (m_st == 2 && hlda && m_rem == 1);
            case (m_st)
                0: if (cfg_load) begin
                       m_rem <= cfg_word_cnt; m_addr <= cfg_start_addr;
                       m_bs <= cfg_blk_size; m_ch <= cfg_chunked;
                       m_pend <= 0; m_done <= 0;
                   end else if ((m_pend || per_req) && m_rem != 0) begin
                       m_st <= 1; m_pend <= 0;
                   end
                1: begin
                       if (per_req) m_pend <= 1;
                       if (hlda) begin m_st <= 2; m_blk <= m_bs; end
                   end
                2: begin
                       if (per_req) m_pend <= 1;
                       if (hlda) begin
                           m_addr <= m_addr + AW'(1); m_rem <= m_rem - 1; m_blk <= m_blk - 1;
                           if (m_rem == 1) m_done <= 1;
                           if (m_rem == 1 || (m_ch && m_blk <= 1)) m_st <= 3;
                       end
                   end
                default: begin
                       if (per_req) m_pend <= 1;
                       if (!hlda) m_st <= 0;
                   end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Hold-period bookkeeping for directed checks.
    int words_now = 0, holds = 0;
    int bursts[$];
    bit prev_hold = 0;
    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            bit eoe;
            eoe = (m_st == 2) && hlda;
            chk(hold_req == (m_st == 1 || m_st == 2), "R7", "hold_req", hold_req, (m_st == 1 || m_st == 2));
            chk(bus_oe == eoe && mem_strobe == eoe && mem_we == eoe && per_ack == eoe,
                "R3", "bus drive", bus_oe, eoe);
            chk(mem_addr == (eoe ? m_addr : '0), "R4", "mem_addr", mem_addr, eoe ? m_addr : 0);
            chk(mem_wdata == (eoe ? per_data : '0), "R4", "mem_wdata", mem_wdata, eoe ? per_data : 0);
            chk(done == m_done, "R9", "done", done, m_done);
            chk(done_pulse == m_dp, "R9", "done_pulse", done_pulse, m_dp);
            if (bus_oe) words_now++;
            if (prev_hold && !hold_req) begin bursts.push_back(words_now); words_now = 0; holds++; end
            prev_hold = hold_req;
        end
        per_data <= per_data + DW'(7);
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic load(input int a, input int n, input int bs, input bit ch);
        @(negedge clk);
        cfg_load = 1; cfg_start_addr = AW'(a); cfg_word_cnt = CW'(n);
        cfg_blk_size = CW'(bs); cfg_chunked = ch;
        @(negedge clk); cfg_load = 0;
    endtask

    task automatic pulse_req();
        @(negedge clk); per_req = 1;
        @(negedge clk); per_req = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (hold_req || hlda) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(!hold_req && !bus_oe && !mem_strobe && !mem_we && !per_ack && !done && !done_pulse
            && mem_addr == 0 && mem_wdata == 0, "R1", "reset outputs", hold_req, 0);
        cmp_en = 1;

        // Continuous run of 5 words, grant latency 2.
        lat = 2;
        load('h1000, 5, 2, 0);
        @(negedge clk); per_req = 1;
        @(negedge clk); per_req = 0;
        chk(hold_req == 1, "R2", "hold after request", hold_req, 1);
        wait_idle();
        chk(bursts.size() == 1 && bursts[0] == 5, "R6", "single hold period words",
            bursts.size() ? bursts[0] : -1, 5);
        chk(done == 1, "R9", "done held", done, 1);
        bursts.delete(); holds = 0;

        // Chunked 7 words, block 3; second request latched mid-block.
        lat = 1;
        load('h2000, 7, 3, 1);
        chk(done == 0, "R9", "done cleared by load", done, 0);
        pulse_req();
        @(negedge clk); per_req = 1;
        @(negedge clk); per_req = 0;
        wait_idle(); wait_idle();
        chk(holds == 2, "R8", "latched request served", holds, 2);
        repeat (5) @(negedge clk);
        chk(hold_req == 0, "R5", "no hold without request", hold_req, 0);
        pulse_req();
        wait_idle();
        chk(bursts.size() == 3 && bursts[0] == 3 && bursts[1] == 3 && bursts[2] == 1,
            "R5", "block sizes", bursts.size(), 3);
        bursts.delete(); holds = 0;

        // Reload attempted mid-run is ignored.
        lat = 3;
        load('hFFFE, 4, 0, 0);
        pulse_req();
        repeat (5) @(negedge clk);
        cfg_load = 1; cfg_start_addr = 'h5555; cfg_word_cnt = 9;
        @(negedge clk); cfg_load = 0;
        wait_idle();
        chk(bursts.size() == 1 && bursts[0] == 4, "R10", "busy reload ignored",
            bursts.size() ? bursts[0] : -1, 4);
        bursts.delete();

        // Chunked with block size 0 acts as 1.
        load('h3000, 2, 0, 1);
        pulse_req(); wait_idle();
        chk(bursts.size() == 1 && bursts[0] == 1, "R5", "zero block size", bursts.size() ? bursts[0] : -1, 1);
        bursts.delete();

        // Zero-count run never requests the bus.
        load('h4000, 0, 1, 0);
        pulse_req();
        repeat (6) @(negedge clk);
        chk(hold_req == 0 && holds == 2, "R10", "zero count no hold", hold_req, 0);

        cmp_en = 0;
        finish_run();
    end
endmodule